// File: doc/BRIEF.md
# Flash Page Buffer Loader

This block sits in front of a flash program engine. It holds a page of 128 sixteen-bit words and collects them from the host write port under one of two command sequences. In a sequential page load the host writes opcode 41h and then exactly 128 data words, with the low seven address bits stepping through every index in order. Once the last word lands, the block asks the program engine to program the whole page. In a random load each word arrives as its own pair: opcode 74h, then a write whose low seven address bits pick the column.

A random-loaded buffer is passed to the engine with the pair 0Eh/D0h and is discarded with the pair 55h/D0h. The program request is a level held until the engine acknowledges completion. At that point the buffer and its per-word valid map empty themselves, so the engine programs only the words marked valid. The engine and any debug logic can read each buffered word and its valid bit through a read port.

Every command is taken from the low byte of the write data on a write strobe. A write is in bank I when its address is below the parameter `BANK1_TOP`, which defaults to 20000h.

Top module: `pgbuf_loader`

## Requirements
- R1: After reset, every valid bit is 0, every stored word reads 0, `flush_req` is 0 and `seq_err` is 0.
- R2: The command 41h, written at any address in either bank, starts a sequential load. The k-th following data write (k = 0..127) is stored at index k only when its address bits [6:0] equal k. The edge that accepts index 127 raises `flush_req`.
- R3: During a sequential load, a data write whose address bits [6:0] differ from the expected index ends the load. On that edge `seq_err` is set and all words and valid bits are cleared, and the next write is decoded as a command.
- R4: The command 74h at a bank I address, followed by one write, stores that write's data at index address[6:0] and sets that index's valid bit. No other word changes.
- R5: The commands 74h and 0Eh at an address at or above `BANK1_TOP` are ignored, and the write after them is decoded as a command.
- R6: The command 0Eh at a bank I address, followed by D0h, raises `flush_req`. Any other second byte cancels the pair and leaves the buffer unchanged.
- R7: `flush_req` stays high until `flush_ack` is sampled high. Writes made while it is high have no effect.
- R8: The edge that samples `flush_ack` high while `flush_req` is high clears every word and valid bit and drops `flush_req`.
- R9: The command 55h followed by D0h clears every word and valid bit. The command 55h followed by any other byte leaves the buffer unchanged.
- R10: A write in the command state whose low byte is not 41h, 74h, 0Eh or 55h has no effect.
- R11: `seq_err` stays set until the next 41h command, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | AW (20) | Write address; bits [6:0] give the column |
| wr_data | input | DW (16) | Write data; bits [7:0] carry the opcode in command cycles |
| flush_req | output | 1 | Request to program the buffered page |
| flush_ack | input | 1 | Program engine finished; clears the buffer |
| vld_map | output | PAGE_WORDS (128) | Per-word valid bits |
| rd_idx | input | IW (7) | Read index |
| rd_data | output | DW (16) | Word stored at `rd_idx` |
| rd_vld | output | 1 | Valid bit at `rd_idx` |
| seq_err | output | 1 | Sticky sequential-load index error |

## Verification
The hardest case to reach is the whole sequential page. The final index and the request it triggers appear only after 129 correctly ordered writes. The abort path needs a long run that breaks off partway through. The stimulus therefore drives full 128-word loads from bank II addresses with data derived from the index, and compares every word. It also runs a load that breaks at index 10 over a buffer already holding random-loaded words, to show that the abort wipes those words too. A behavioural model mirrors the command sequencing and is compared with every output on every cycle, including writes made while a flush is waiting.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_SEQ   = 3'd1,
        S_SGL   = 3'd2,
        S_FCONF = 3'd3,
        S_CCONF = 3'd4,
        S_FLUSH = 3'd5
    } ld_state_e;

    localparam logic [7:0] OP_SEQ   = 8'h41;
    localparam logic [7:0] OP_SGL   = 8'h74;
    localparam logic [7:0] OP_FLUSH = 8'h0E;
    localparam logic [7:0] OP_CLR   = 8'h55;
    localparam logic [7:0] OP_CONF  = 8'hD0;
endpackage

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
    import pgbuf_pkg::*;
#(
    parameter int unsigned AW = 20,
    parameter int unsigned DW = 16,
    parameter int unsigned IW = 7,
    parameter logic [AW-1:0] BANK1_TOP = AW'(32'h2_0000)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          flush_ack,
    output logic          st_we,
    output logic [IW-1:0] st_idx,
    output logic [DW-1:0] st_data,
    output logic          st_clr,
    output logic          flush_req,
    output logic          seq_err
);
    localparam logic [IW-1:0] LAST_IDX = {IW{1'b1}};
    localparam logic [IW-1:0] ONE_IDX  = {{(IW-1){1'b0}}, 1'b1};

    typedef struct packed {
        ld_state_e     st;
        logic [IW-1:0] idx;
        logic          err;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  in_bank1;
    logic [7:0] op;

    always_comb begin
        ctl_d    = ctl_q;
        st_we    = 1'b0;
        st_clr   = 1'b0;
        st_idx   = wr_addr[IW-1:0];
        st_data  = wr_data;
        in_bank1 = (wr_addr < BANK1_TOP);
        op       = wr_data[7:0];
        case (ctl_q.st)
            S_IDLE: begin
                if (wr_en) begin
                    case (op)
                        OP_SEQ: begin
                            ctl_d.st  = S_SEQ;
                            ctl_d.idx = '0;
                            ctl_d.err = 1'b0;
                        end
                        OP_SGL:   if (in_bank1) ctl_d.st = S_SGL;
                        OP_FLUSH: if (in_bank1) ctl_d.st = S_FCONF;
                        OP_CLR:   ctl_d.st = S_CCONF;
                        default:  ctl_d.st = S_IDLE;
                    endcase
                end
            end
            S_SEQ: begin
                if (wr_en) begin
                    if (wr_addr[IW-1:0] == ctl_q.idx) begin
                        st_we     = 1'b1;
                        st_idx    = ctl_q.idx;
                        ctl_d.idx = ctl_q.idx + ONE_IDX;
                        if (ctl_q.idx == LAST_IDX) ctl_d.st = S_FLUSH;
                    end else begin
                        st_clr    = 1'b1;
                        ctl_d.err = 1'b1;
                        ctl_d.st  = S_IDLE;
                    end
                end
            end
            S_SGL: begin
                if (wr_en) begin
                    st_we    = 1'b1;
                    ctl_d.st = S_IDLE;
                end
            end
            S_FCONF: begin
                if (wr_en) ctl_d.st = (op == OP_CONF) ? S_FLUSH : S_IDLE;
            end
            S_CCONF: begin
                if (wr_en) begin
                    st_clr   = (op == OP_CONF);
                    ctl_d.st = S_IDLE;
                end
            end
            S_FLUSH: begin
                if (flush_ack) begin
                    st_clr   = 1'b1;
                    ctl_d.st = S_IDLE;
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st  <= S_IDLE;
            ctl_q.idx <= '0;
            ctl_q.err <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign flush_req = (ctl_q.st == S_FLUSH);
    assign seq_err   = ctl_q.err;
endmodule

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
    parameter int unsigned WORDS = 128,
    parameter int unsigned DW    = 16,
    parameter int unsigned IW    = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_we,
    input  logic [IW-1:0]    st_idx,
    input  logic [DW-1:0]    st_data,
    input  logic             st_clr,
    input  logic [IW-1:0]    rd_idx,
    output logic [DW-1:0]    rd_data,
    output logic             rd_vld,
    output logic [WORDS-1:0] vld_map
);
    typedef struct packed {
        logic [WORDS-1:0][DW-1:0] mem;
        logic [WORDS-1:0]         vld;
    } store_t;

    store_t sto_d, sto_q;

    always_comb begin
        sto_d = sto_q;
        if (st_clr) begin
            sto_d = '0;
        end else if (st_we) begin
            sto_d.mem[st_idx] = st_data;
            sto_d.vld[st_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sto_q <= '0;
        else        sto_q <= sto_d;
    end

    assign rd_data = sto_q.mem[rd_idx];
    assign rd_vld  = sto_q.vld[rd_idx];
    assign vld_map = sto_q.vld;
endmodule

// File: rtl/pgbuf_loader.sv
module pgbuf_loader #(
    parameter int unsigned AW         = 20,
    parameter int unsigned DW         = 16,
    parameter int unsigned PAGE_WORDS = 128,
    parameter int unsigned IW         = $clog2(PAGE_WORDS),
    parameter logic [AW-1:0] BANK1_TOP = AW'(32'h2_0000)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [DW-1:0]         wr_data,
    output logic                  flush_req,
    input  logic                  flush_ack,
    output logic [PAGE_WORDS-1:0] vld_map,
    input  logic [IW-1:0]         rd_idx,
    output logic [DW-1:0]         rd_data,
    output logic                  rd_vld,
    output logic                  seq_err
);
    logic          st_we;
    logic          st_clr;
    logic [IW-1:0] st_idx;
    logic [DW-1:0] st_data;

    pgbuf_ctrl #(
        .AW(AW), .DW(DW), .IW(IW), .BANK1_TOP(BANK1_TOP)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .flush_ack(flush_ack), .st_we(st_we),
        .st_idx(st_idx), .st_data(st_data), .st_clr(st_clr),
        .flush_req(flush_req), .seq_err(seq_err)
    );

    pgbuf_store #(
        .WORDS(PAGE_WORDS), .DW(DW), .IW(IW)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .st_we(st_we), .st_idx(st_idx),
        .st_data(st_data), .st_clr(st_clr), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_vld(rd_vld), .vld_map(vld_map)
    );
endmodule

// File: rtl/pgbuf_loader_chk.sv
module pgbuf_loader_chk #(
    parameter int unsigned WORDS = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             flush_req,
    input logic             flush_ack,
    input logic [WORDS-1:0] vld_map,
    input logic             seq_err
);
    // R7
    flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && !flush_ack |=> flush_req);

    // R8
    flush_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && flush_ack |=> !flush_req && (vld_map == '0));

    // R3
    abort_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> (vld_map == '0) && !flush_req);

    // R4
    vld_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_map != $past(vld_map)) |-> ($past(wr_en) || $past(flush_ack)));

    // R11
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> $past(wr_en));
endmodule

bind pgbuf_loader pgbuf_loader_chk #(.WORDS(PAGE_WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .flush_req(flush_req),
    .flush_ack(flush_ack), .vld_map(vld_map), .seq_err(seq_err)
);

// File: tb/pgbuf_loader_bench.sv
module pgbuf_loader_bench;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int NW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          flush_ack = 1'b0;
    logic [6:0]    rd_idx = '0;
    logic          flush_req, rd_vld, seq_err;
    logic [NW-1:0] vld_map;
    logic [DW-1:0] rd_data;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // behavioural model
    int          m_mode;   // 0 cmd, 1 seq, 2 single, 3 flush confirm, 4 clear confirm, 5 flushing
    int          m_idx;
    bit          m_err;
    int          m_mem [NW];
    bit [NW-1:0] m_vld;

    pgbuf_loader u_pgbuf_loader (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .flush_req(flush_req), .flush_ack(flush_ack),
        .vld_map(vld_map), .rd_idx(rd_idx), .rd_data(rd_data),
        .rd_vld(rd_vld), .seq_err(seq_err)
    );

    always #2.5 clk = ~clk;

    task automatic m_clear();
        for (int i = 0; i < NW; i++) m_mem[i] = 0;
        m_vld = '0;
    endtask

    task automatic chk(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int op;
        bit b1;
        if (!rst_n) begin
            m_mode = 0; m_idx = 0; m_err = 0; m_clear();
        end else if (m_mode == 5) begin
            if (flush_ack) begin m_clear(); m_mode = 0; end
        end else if (wr_en) begin
            op = int'(wr_data[7:0]);
            b1 = (wr_addr < 20'h20000);
            case (m_mode)
                0: begin
                    if (op == 'h41) begin m_mode = 1; m_idx = 0; m_err = 0; end
                    else if (op == 'h74 && b1) m_mode = 2;
                    else if (op == 'h0E && b1) m_mode = 3;
                    else if (op == 'h55) m_mode = 4;
                end
                1: begin
                    if (int'(wr_addr[6:0]) == m_idx) begin
                        m_mem[m_idx] = int'(wr_data);
                        m_vld[m_idx] = 1'b1;
                        if (m_idx == NW - 1) m_mode = 5;
                        m_idx++;
                    end else begin
                        m_clear(); m_err = 1; m_mode = 0;
                    end
                end
                2: begin
                    m_mem[wr_addr[6:0]] = int'(wr_data);
                    m_vld[wr_addr[6:0]] = 1'b1;
                    m_mode = 0;
                end
                3: m_mode = (op == 'hD0) ? 5 : 0;
                4: begin
                    if (op == 'hD0) m_clear();
                    m_mode = 0;
                end
                default: m_mode = 0;
            endcase
        end
        #1.5;
        if (rst_n) begin
            total++;
            if (flush_req !== (m_mode == 5) || seq_err !== m_err || vld_map !== m_vld ||
                rd_vld !== m_vld[rd_idx] || int'(rd_data) != m_mem[rd_idx]) begin
                bad++;
                $display("FAIL %s model compare actual req=%0b err=%0b data=%0h expected req=%0b err=%0b data=%0h",
                         cur_req, flush_req, seq_err, rd_data, (m_mode == 5), m_err, m_mem[rd_idx]);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); flush_ack = 1'b1;
        @(negedge clk); flush_ack = 1'b0;
    endtask

    task automatic peek(input string req, input int idx, input int exp_d, input int exp_v);
        @(negedge clk);
        rd_idx = 7'(idx);
        #1;
        chk(req, int'(rd_data), exp_d, "rd_data");
        chk(req, int'(rd_vld), exp_v, "rd_vld");
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1";
        peek("R1", 0, 0, 0);
        chk("R1", int'(flush_req), 0, "flush_req");
        chk("R1", int'(seq_err), 0, "seq_err");
        chk("R1", int'(vld_map != '0), 0, "vld_map");

        // R4 random loads in bank I
        cur_req = "R4";
        wr(20'h00005, 16'h0074); wr(20'h00005, 16'h1234);
        wr(20'h1FF7F, 16'h0074); wr(20'h1FF7F, 16'hBEEF);
        peek("R4", 5, 'h1234, 1);
        peek("R4", 127, 'hBEEF, 1);
        peek("R4", 6, 0, 0);

        // R5 bank II single load ignored; following data decoded as command
        cur_req = "R5";
        wr(20'h30009, 16'h0074); wr(20'h30009, 16'h5577);
        peek("R5", 9, 0, 0);
        chk("R5", $countones(vld_map), 2, "valid count");
        wr(20'h30000, 16'h000E); wr(20'h30000, 16'h00D0);
        chk("R5", int'(flush_req), 0, "flush_req");

        // R10 unknown opcode
        cur_req = "R10";
        wr(20'h00009, 16'h0012); wr(20'h00009, 16'h0099);
        chk("R10", $countones(vld_map), 2, "valid count");

        // R9 clear cancel then clear
        cur_req = "R9";
        wr(20'h00000, 16'h0055); wr(20'h00000, 16'h00FF);
        peek("R9", 5, 'h1234, 1);
        wr(20'h00000, 16'h0055); wr(20'h00000, 16'h00D0);
        peek("R9", 5, 0, 0);
        chk("R9", int'(vld_map != '0), 0, "vld_map");

        // R6 flush cancel then flush; R7 writes ignored; R8 ack clears
        cur_req = "R6";
        wr(20'h00010, 16'h0074); wr(20'h00010, 16'hA5A5);
        wr(20'h00000, 16'h000E); wr(20'h00000, 16'h0001);
        chk("R6", int'(flush_req), 0, "flush_req after cancel");
        peek("R6", 16, 'hA5A5, 1);
        wr(20'h00000, 16'h000E); wr(20'h00000, 16'h00D0);
        chk("R6", int'(flush_req), 1, "flush_req");
        cur_req = "R7";
        wr(20'h00020, 16'h0074); wr(20'h00020, 16'h7777);
        wr(20'h00000, 16'h0055); wr(20'h00000, 16'h00D0);
        repeat (3) @(negedge clk);
        chk("R7", int'(flush_req), 1, "flush_req held");
        peek("R7", 32, 0, 0);
        peek("R7", 16, 'hA5A5, 1);
        cur_req = "R8";
        ack();
        chk("R8", int'(flush_req), 0, "flush_req");
        peek("R8", 16, 0, 0);

        // R2 full sequential load from bank II
        cur_req = "R2";
        wr(20'h40000, 16'h0041);
        for (int i = 0; i < NW; i++) begin
            if (i == NW - 1) chk("R2", int'(flush_req), 0, "flush_req early");
            wr(20'h40000 + 20'(i), 16'(i * 3 + 1));
        end
        chk("R2", int'(flush_req), 1, "flush_req after last");
        for (int i = 0; i < NW; i++) peek("R2", i, i * 3 + 1, 1);
        cur_req = "R8";
        ack();
        chk("R8", int'(vld_map != '0), 0, "vld_map");

        // R3 out-of-order sequential write aborts and wipes earlier single loads
        cur_req = "R3";
        wr(20'h00044, 16'h0074); wr(20'h00044, 16'h4444);
        wr(20'h00000, 16'h0041);
        for (int i = 0; i < 10; i++) wr(20'h00000 + 20'(i), 16'(16'h100 + i));
        wr(20'h0000B, 16'hDEAD);
        chk("R3", int'(seq_err), 1, "seq_err");
        chk("R3", int'(vld_map != '0), 0, "vld_map");
        peek("R3", 68, 0, 0);
        wr(20'h00003, 16'h0074); wr(20'h00003, 16'h3333);
        peek("R3", 3, 'h3333, 1);
        cur_req = "R11";
        chk("R11", int'(seq_err), 1, "seq_err sticky");
        wr(20'h00000, 16'h0041);
        chk("R11", int'(seq_err), 0, "seq_err cleared");
        wr(20'h00001, 16'h0000);
        chk("R11", int'(seq_err), 1, "seq_err again");
        summary();
        $finish;
    end
endmodule